// File: doc/BRIEF.md
# Serial Receive Queue

This block is the receive half of an asynchronous serial port. It watches an idle-high line, detects a falling start bit, and confirms the start bit at its midpoint. It then samples each later bit at its centre and collects 7 or 8 data bits, least-significant bit first. An optional parity bit follows, then one or two stop bits. At the end of each frame it decides whether to keep the byte, and kept bytes enter a 16-entry first-word-fall-through queue. Six sticky status flags track the queue level and the errors seen. Three interrupt outputs are derived from those flags and two enable inputs.

The bit timing comes from an external tick at sixteen times the bit rate. The frame engine is a state machine with seven states:
- `RX_IDLE` waits for a low sample on a tick, then goes to `RX_START`.
- `RX_START` returns to `RX_IDLE` if the mid-bit sample is high (a false start). Otherwise it goes to `RX_DATA`.
- `RX_DATA` loops once per data bit. After the last bit it goes to `RX_PARITY` when parity is enabled, else to `RX_STOP1`.
- `RX_PARITY` goes to `RX_STOP1`.
- `RX_STOP1` completes the frame. A low stop bit sends it to `RX_HOLD`. A high stop bit sends it to `RX_STOP2` when two stop bits are set, else to `RX_IDLE`.
- `RX_STOP2` waits one more bit without checking it. It then goes to `RX_IDLE` if the line is high, or to `RX_HOLD` if it is low.
- `RX_HOLD` waits for the line to go high, then returns to `RX_IDLE`.

Software reads bytes with a pop strobe and clears flags with a per-flag clear vector.

Top module: `serial_rx_queue`

## Requirements
- R1: A low line sampled on a baud tick begins a frame only if the sample 8 ticks later is also low. A low pulse shorter than half a bit stores nothing and sets no flag.
- R2: Data bits are assembled least-significant bit first. `cfg_seven`=1 selects 7 data bits, and such bytes read back with bit 7 equal to 0. `cfg_seven`=0 selects 8 bits.
- R3: When `cfg_par_en`=1, one parity bit follows the data. The parity is even when `cfg_par_odd`=0 and odd when it is 1. A mismatch sets flag bit 2, and the byte is still stored.
- R4: The first stop bit must be 1, otherwise flag bit 3 (framing) is set and a nonzero byte is still stored. When `cfg_two_stop`=1, the second stop bit is never checked.
- R5: After a parity or framing error, the next frame is received and stored normally.
- R6: The queue holds 16 bytes. `rd_data` shows the oldest byte, `rd_pop` removes it, and `fill` gives the number held.
- R7: A completed frame is stored only if the queue has room, flag bit 4 is clear and flag bit 5 is clear. Otherwise it is dropped.
- R8: A frame that completes while the queue holds 16 bytes sets flag bit 4 (overrun) and is dropped.
- R9: A frame whose data bits are all 0 and whose first stop bit is 0 sets flag bit 5 (break) and flag bit 3, and is not stored.
- R10: Flag bit 0 sets when `fill` is at least the trigger chosen by `cfg_trig`: 0→1, 1→4, 2→8, 3→14 bytes.
- R11: Flag bit 1 sets when `fill` is nonzero and below the trigger, and 15 bit times (240 ticks) have passed in `RX_IDLE` since the last start detection.
- R12: Each flag stays set until its bit in `flag_clr` is pulsed. If the flag's set condition is true in the same cycle, the set wins.
- R13: The interrupt outputs are:
  - `irq_rx` = `ien_rx` and (bit 0 or bit 1).
  - `irq_err` = (`ien_rx` or `ien_err`) and (bit 2 or bit 3).
  - `irq_brk` = (`ien_rx` or `ien_err`) and (bit 4 or bit 5).
- R14: After reset, `fill` is 0, all flags are 0 and all interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_seven | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_trig | input | 2 | Queue trigger select (1/4/8/14) |
| ien_rx | input | 1 | Receive interrupt enable |
| ien_err | input | 1 | Error interrupt enable |
| rd_pop | input | 1 | Remove the oldest byte |
| flag_clr | input | 6 | Per-flag clear strobes, same bit order as `rx_flags` |
| rd_data | output | 8 | Oldest queued byte |
| fill | output | 5 | Number of queued bytes |
| rx_flags | output | 6 | [0] trigger, [1] ready, [2] parity, [3] framing, [4] overrun, [5] break |
| irq_rx | output | 1 | Receive-data interrupt |
| irq_err | output | 1 | Receive-error interrupt |
| irq_brk | output | 1 | Break/overrun interrupt |

## Verification
The bench builds the block with its defaults: depth 16, 16x oversampling, a 15-bit-time idle limit and two synchroniser stages. It supplies a tick every fourth clock, so one bit lasts 64 clocks. With a depth of 16, the overrun and queue-full cases take only seventeen frames. The trigger levels of 1, 4 and 14 fall inside that depth, and the 240-tick idle limit expires within about a thousand clocks.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP1,
        RX_STOP2,
        RX_HOLD
    } rx_state_t;

    localparam int FLAG_W = 6;
    localparam int F_THR  = 0;
    localparam int F_RDY  = 1;
    localparam int F_PERR = 2;
    localparam int F_FERR = 3;
    localparam int F_OVR  = 4;
    localparam int F_BRK  = 5;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } frame_res_t;

    function automatic int trig_level(input logic [1:0] sel);
        int lvl;
        unique case (sel)
            2'd0:    lvl = 1;
            2'd1:    lvl = 4;
            2'd2:    lvl = 8;
            default: lvl = 14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rxq_frame.sv
module rxq_frame
    import rxq_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic       tick_i,
    input  logic       seven_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       two_stop_i,
    output logic       idle_o,
    output logic       start_o,
    output logic       done_o,
    output frame_res_t res_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    rx_state_t        state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       shreg;
    logic             par_acc;
    logic             centre;
    logic             last_bit;
    logic [7:0]       byte_now;

    assign centre   = tick_i && (cnt == LAST);
    assign last_bit = (bit_idx == (seven_i ? 3'd6 : 3'd7));
    assign byte_now = seven_i ? {1'b0, shreg[7:1]} : shreg;
    assign idle_o   = (state == RX_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:   if (tick_i && !line_i) nxt = RX_START;
            RX_START:  if (tick_i && cnt == MID) nxt = line_i ? RX_IDLE : RX_DATA;
            RX_DATA:   if (centre && last_bit) nxt = par_en_i ? RX_PARITY : RX_STOP1;
            RX_PARITY: if (centre) nxt = RX_STOP1;
            RX_STOP1: begin
                if (centre) begin
                    if (!line_i)         nxt = RX_HOLD;
                    else if (two_stop_i) nxt = RX_STOP2;
                    else                 nxt = RX_IDLE;
                end
            end
            RX_STOP2:  if (centre) nxt = line_i ? RX_IDLE : RX_HOLD;
            RX_HOLD:   if (line_i) nxt = RX_IDLE;
            default:   nxt = RX_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            done_o  <= 1'b0;
            start_o <= 1'b0;
            res_o   <= '0;
        end else begin
            done_o  <= 1'b0;
            start_o <= 1'b0;
            if (state != nxt)
                cnt <= '0;
            else if (tick_i && state != RX_IDLE && state != RX_HOLD)
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            unique case (state)
                RX_IDLE:  if (nxt == RX_START) start_o <= 1'b1;
                RX_START: begin
                    bit_idx <= '0;
                    par_acc <= 1'b0;
                end
                RX_DATA: if (centre) begin
                    shreg   <= {line_i, shreg[7:1]};
                    par_acc <= par_acc ^ line_i;
                    bit_idx <= bit_idx + 3'd1;
                end
                RX_PARITY: if (centre) par_acc <= par_acc ^ line_i;
                RX_STOP1: if (centre) begin
                    done_o     <= 1'b1;
                    res_o.data <= byte_now;
                    res_o.perr <= par_en_i && (par_acc != par_odd_i);
                    res_o.ferr <= !line_i;
                    res_o.brk  <= !line_i && (byte_now == 8'h00);
                end
                default: ;
            endcase
        end
    end

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> state == RX_START);

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  wdata_i,
    input  logic          pop_i,
    output logic [W-1:0]  rdata_o,
    output logic [CW-1:0] count_o
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign do_push = push_i && (count_o != CW'(DEPTH));
    assign do_pop  = pop_i && (count_o != '0);
    assign rdata_o = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count_o <= count_o + 1'b1;
                2'b01:   count_o <= count_o - 1'b1;
                default: count_o <= count_o;
            endcase
        end
    end

    // R6
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && count_o == '0 && !push_i) |=> count_o == '0);

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && count_o == CW'(DEPTH)) |=> count_o == CW'(DEPTH));

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int OVS       = 16,
    parameter int IDLE_BITS = 15,
    parameter int CW        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              idle_i,
    input  logic              start_i,
    input  logic              done_i,
    input  logic              perr_i,
    input  logic              ferr_i,
    input  logic              brk_i,
    input  logic [CW-1:0]     count_i,
    input  logic [1:0]        trig_sel_i,
    input  logic [FLAG_W-1:0] clr_i,
    input  logic              ien_rx_i,
    input  logic              ien_err_i,
    output logic              push_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              irq_rx_o,
    output logic              irq_err_o,
    output logic              irq_brk_o
);
    localparam int TO_LIM = OVS * IDLE_BITS;
    localparam int TO_W   = $clog2(TO_LIM + 1);

    logic [TO_W-1:0]   to_cnt;
    logic              to_hit;
    logic [CW-1:0]     trig;
    logic              room;
    logic [FLAG_W-1:0] set_v;
    logic [FLAG_W-1:0] flags_q;

    assign trig   = CW'(trig_level(trig_sel_i));
    assign to_hit = (to_cnt == TO_W'(TO_LIM));
    assign room   = (count_i < CW'(DEPTH));
    assign push_o = done_i && !brk_i && room && !flags_q[F_OVR] && !flags_q[F_BRK];

    always_comb begin
        set_v         = '0;
        set_v[F_THR]  = (count_i >= trig);
        set_v[F_RDY]  = (count_i != '0) && (count_i < trig) && to_hit;
        set_v[F_PERR] = done_i && perr_i;
        set_v[F_FERR] = done_i && ferr_i;
        set_v[F_OVR]  = done_i && !brk_i && !room;
        set_v[F_BRK]  = done_i && brk_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_cnt  <= '0;
            flags_q <= '0;
        end else begin
            if (start_i)
                to_cnt <= '0;
            else if (idle_i && tick_i && !to_hit)
                to_cnt <= to_cnt + 1'b1;
            flags_q <= (flags_q & ~clr_i) | set_v;
        end
    end

    assign flags_o   = flags_q;
    assign irq_rx_o  = ien_rx_i && (flags_q[F_THR] || flags_q[F_RDY]);
    assign irq_err_o = (ien_rx_i || ien_err_i) && (flags_q[F_PERR] || flags_q[F_FERR]);
    assign irq_brk_o = (ien_rx_i || ien_err_i) && (flags_q[F_OVR] || flags_q[F_BRK]);

    // R12
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[F_OVR] && !clr_i[F_OVR]) |=> flags_q[F_OVR]);

    // R12
    brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[F_BRK] && !clr_i[F_BRK]) |=> flags_q[F_BRK]);

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int OVS         = 16,
    parameter int IDLE_BITS   = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rxd,
    input  logic                         baud_tick,
    input  logic                         cfg_seven,
    input  logic                         cfg_par_en,
    input  logic                         cfg_par_odd,
    input  logic                         cfg_two_stop,
    input  logic [1:0]                   cfg_trig,
    input  logic                         ien_rx,
    input  logic                         ien_err,
    input  logic                         rd_pop,
    input  logic [5:0]                   flag_clr,
    output logic [7:0]                   rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   fill,
    output logic [5:0]                   rx_flags,
    output logic                         irq_rx,
    output logic                         irq_err,
    output logic                         irq_brk
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line_s;
    logic                   frame_idle, frame_start, frame_done, push;
    frame_res_t             frame_res;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end
    assign line_s = sync_q[SYNC_STAGES-1];

    rxq_frame #(.OVS(OVS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_s),
        .tick_i     (baud_tick),
        .seven_i    (cfg_seven),
        .par_en_i   (cfg_par_en),
        .par_odd_i  (cfg_par_odd),
        .two_stop_i (cfg_two_stop),
        .idle_o     (frame_idle),
        .start_o    (frame_start),
        .done_o     (frame_done),
        .res_o      (frame_res)
    );

    rxq_status #(.DEPTH(DEPTH), .OVS(OVS), .IDLE_BITS(IDLE_BITS), .CW(CW)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (baud_tick),
        .idle_i     (frame_idle),
        .start_i    (frame_start),
        .done_i     (frame_done),
        .perr_i     (frame_res.perr),
        .ferr_i     (frame_res.ferr),
        .brk_i      (frame_res.brk),
        .count_i    (fill),
        .trig_sel_i (cfg_trig),
        .clr_i      (flag_clr),
        .ien_rx_i   (ien_rx),
        .ien_err_i  (ien_err),
        .push_o     (push),
        .flags_o    (rx_flags),
        .irq_rx_o   (irq_rx),
        .irq_err_o  (irq_err),
        .irq_brk_o  (irq_brk)
    );

    rxq_fifo #(.DEPTH(DEPTH), .W(8), .CW(CW)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .wdata_i (frame_res.data),
        .pop_i   (rd_pop),
        .rdata_o (rd_data),
        .count_o (fill)
    );

    // R7
    discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && (rx_flags[F_OVR] || rx_flags[F_BRK]) && !rd_pop) |=> fill == $past(fill));

    // R9
    brk_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_res.brk && !rd_pop) |=> fill == $past(fill));

    // R8
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_res.brk && fill == CW'(DEPTH)) |=> rx_flags[F_OVR]);

    // R13
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien_rx && !ien_err) |-> !(irq_rx || irq_err || irq_brk));

endmodule

// File: tb/serial_rx_queue_tb.sv
module serial_rx_queue_tb;
    localparam int DEPTH    = 16;
    localparam int CW       = $clog2(DEPTH + 1);
    localparam int BIT_CLKS = 64;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          rxd = 1'b1;
    logic          baud_tick = 1'b0;
    logic [1:0]    tdiv = 2'd0;
    logic          seven = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic [1:0]    trig = 2'd0;
    logic          ien_rx = 1'b0, ien_err = 1'b0;
    logic          rd_pop = 1'b0;
    logic [5:0]    flag_clr = 6'd0;
    logic [7:0]    rd_data;
    logic [CW-1:0] fill;
    logic [5:0]    rx_flags;
    logic          irq_rx, irq_err, irq_brk;

    int   checks = 0;
    int   errors = 0;
    bit   drain_en = 1'b1;
    bit   finished = 1'b0;
    logic [7:0] exp_q[$];

    serial_rx_queue u_dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
        .cfg_seven(seven), .cfg_par_en(par_en), .cfg_par_odd(par_odd),
        .cfg_two_stop(two_stop), .cfg_trig(trig), .ien_rx(ien_rx),
        .ien_err(ien_err), .rd_pop(rd_pop), .flag_clr(flag_clr),
        .rd_data(rd_data), .fill(fill), .rx_flags(rx_flags),
        .irq_rx(irq_rx), .irq_err(irq_err), .irq_brk(irq_brk)
    );

    always @(negedge clk) begin
        tdiv      <= tdiv + 2'd1;
        baud_tick <= (tdiv == 2'd3);
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops the queue and compares with the scoreboard (R6, R2)
    always @(negedge clk) begin
        if (rd_pop) rd_pop = 1'b0;
        else if (drain_en && rst_n && fill != '0) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7: got unexpected byte %0d expected none", rd_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL R2: got %0d expected %0d", rd_data, e);
                end
            end
            rd_pop = 1'b1;
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(input logic b);
        @(negedge clk);
        rxd = b;
        repeat (BIT_CLKS - 1) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit keep, input bit bad_par,
                        input bit s1, input bit s2);
        int nb;
        logic [7:0] m;
        logic p;
        nb = seven ? 7 : 8;
        m  = seven ? {1'b0, d[6:0]} : d;
        if (keep) exp_q.push_back(m);
        p = (^m) ^ par_odd ^ bad_par;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(m[i]);
        if (par_en) drive_bit(p);
        drive_bit(s1);
        if (two_stop) drive_bit(s2);
        @(negedge clk);
        rxd = 1'b1;
        wait_clks(BIT_CLKS);
    endtask

    task automatic pulse_clr(input logic [5:0] m);
        @(negedge clk);
        flag_clr = m;
        @(negedge clk);
        flag_clr = 6'd0;
        @(negedge clk);
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 200 && (fill != '0 || rd_pop); i++) @(negedge clk);
        wait_clks(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_clks(10);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        chk("R14 fill", int'(fill), 0);
        chk("R14 flags", int'(rx_flags), 0);
        chk("R14 irqs", int'({irq_rx, irq_err, irq_brk}), 0);

        // R2 R6 eight-bit frames, no parity
        send(8'hA5, 1, 0, 1, 1);
        send(8'h3C, 1, 0, 1, 1);
        send(8'h01, 1, 0, 1, 1);
        send(8'h80, 1, 0, 1, 1);
        wait_drain();
        chk("R6 drained", exp_q.size(), 0);
        chk("R10 trigger 1", int'(rx_flags[0]), 1);
        chk("R13 irq_rx gated off", int'(irq_rx), 0);
        ien_rx = 1'b1;
        @(negedge clk);
        chk("R13 irq_rx on", int'(irq_rx), 1);
        pulse_clr(6'b000001);
        chk("R12 clear trigger", int'(rx_flags[0]), 0);
        ien_rx = 1'b0;

        // R3 R5 seven bits, even parity
        seven = 1'b1; par_en = 1'b1; par_odd = 1'b0;
        send(8'h7F, 1, 0, 1, 1);
        wait_drain();
        chk("R3 good even parity", int'(rx_flags[2]), 0);
        send(8'h55, 1, 1, 1, 1);
        wait_drain();
        chk("R3 bad parity flagged", int'(rx_flags[2]), 1);
        send(8'hD2, 1, 0, 1, 1);
        wait_drain();
        chk("R5 receive after error", exp_q.size(), 0);
        ien_err = 1'b1;
        @(negedge clk);
        chk("R13 irq_err", int'(irq_err), 1);
        chk("R13 irq_brk idle", int'(irq_brk), 0);
        pulse_clr(6'b000100);
        chk("R12 clear parity", int'(rx_flags[2]), 0);
        chk("R13 irq_err after clear", int'(irq_err), 0);
        par_odd = 1'b1;
        send(8'h33, 1, 0, 1, 1);
        wait_drain();
        chk("R3 good odd parity", int'(rx_flags[2]), 0);

        // R4 two stop bits
        seven = 1'b0; par_en = 1'b0; two_stop = 1'b1;
        send(8'h5A, 1, 0, 1, 0);
        wait_drain();
        chk("R4 second stop unchecked", int'(rx_flags[3]), 0);
        send(8'h6B, 1, 0, 0, 1);
        wait_drain();
        chk("R4 first stop low", int'(rx_flags[3]), 1);
        two_stop = 1'b0;
        send(8'h11, 1, 0, 1, 1);
        wait_drain();
        chk("R5 after framing error", exp_q.size(), 0);
        pulse_clr(6'b001000);

        // R9 R7 break
        send(8'h00, 0, 0, 0, 1);
        wait_drain();
        chk("R9 break flag", int'(rx_flags[5]), 1);
        chk("R9 framing with break", int'(rx_flags[3]), 1);
        chk("R13 irq_brk", int'(irq_brk), 1);
        drain_en = 1'b0;
        send(8'h77, 0, 0, 1, 1);
        chk("R7 dropped while break set", int'(fill), 0);
        pulse_clr(6'b101000);
        drain_en = 1'b1;
        send(8'h77, 1, 0, 1, 1);
        wait_drain();
        chk("R7 stored after clear", exp_q.size(), 0);

        // R10 R8 trigger of four, then overrun
        pulse_clr(6'h3F);
        drain_en = 1'b0;
        trig = 2'd1;
        for (int i = 0; i < 3; i++) send(8'(i * 7 + 1), 1, 0, 1, 1);
        chk("R10 below four", int'(rx_flags[0]), 0);
        send(8'h40, 1, 0, 1, 1);
        chk("R10 at four", int'(rx_flags[0]), 1);
        for (int i = 4; i < 16; i++) send(8'(i * 13 + 2), 1, 0, 1, 1);
        chk("R6 full", int'(fill), 16);
        chk("R8 no overrun yet", int'(rx_flags[4]), 0);
        send(8'hEE, 0, 0, 1, 1);
        chk("R8 overrun flag", int'(rx_flags[4]), 1);
        chk("R8 still full", int'(fill), 16);
        drain_en = 1'b1;
        wait_drain();
        chk("R8 drained in order", exp_q.size(), 0);
        drain_en = 1'b0;
        send(8'h99, 0, 0, 1, 1);
        chk("R7 dropped while overrun set", int'(fill), 0);
        pulse_clr(6'b010000);
        drain_en = 1'b1;
        send(8'hC3, 1, 0, 1, 1);
        wait_drain();
        chk("R7 stored after overrun clear", exp_q.size(), 0);

        // R11 idle timeout
        pulse_clr(6'h3F);
        drain_en = 1'b0;
        trig = 2'd3;
        ien_rx = 1'b1;
        send(8'h42, 1, 0, 1, 1);
        chk("R11 not yet ready", int'(rx_flags[1]), 0);
        wait_clks(600);
        chk("R11 ready before limit", int'(rx_flags[1]), 0);
        wait_clks(500);
        chk("R11 ready after limit", int'(rx_flags[1]), 1);
        chk("R13 irq_rx from ready", int'(irq_rx), 1);
        drain_en = 1'b1;
        wait_drain();
        pulse_clr(6'h3F);
        ien_rx = 1'b0;

        // R1 false start
        drain_en = 1'b0;
        @(negedge clk);
        rxd = 1'b0;
        wait_clks(16);
        rxd = 1'b1;
        wait_clks(200);
        chk("R1 glitch stores nothing", int'(fill), 0);
        chk("R1 glitch sets no flag", int'(rx_flags), 0);
        send(8'h5C, 1, 0, 1, 1);
        chk("R1 real start", int'(fill), 1);
        drain_en = 1'b1;
        wait_drain();
        chk("R2 scoreboard empty", exp_q.size(), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule